// File: doc/BRIEF.md
# Split Two-Way Address Translation Cache

This block keeps recently used virtual-to-physical page translations so that a requester can turn a 32-bit virtual address into a 30-bit physical address in one cycle. Pages are 512 bytes. The low nine address bits pass straight through, and the upper bits are looked up in a two-way set-associative store of 128 entries. Each entry holds a physical frame number and a four-bit access-rights code. The store is split into two independent halves. Virtual address bit 31 set selects the system half, and bit 31 clear selects the per-process half. Each half has 32 sets of two ways.

A requester presents an address, a write flag and a user-mode flag on the lookup port. One cycle later it receives exactly one of three outcomes: a hit with a physical address, a miss, or a protection fault. A miss parks the block and it refuses further lookups. An external page-table walker then writes the missing entry through the fill port, which releases the block, and the requester retries and hits. Two invalidate inputs drop translations. One clears the per-process half only, and the other clears both halves.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid, `lkReady` is 1 and `rspValid` is 0, so the first lookup to any address misses.
- R2: A lookup is accepted when `lkValid` and `lkReady` are both 1. `rspValid` rises for exactly the following cycle, and a lookup presented while `lkReady` is 0 produces no response.
- R3: On a hit, `rspPa` equals the stored frame number concatenated with `lkVa[8:0]`. The set index is `lkVa[13:9]`, the tag is `lkVa[30:14]` and the half is `lkVa[31]`.
- R4: The rights code bit at index {user, write} grants the access (bit0 kernel read, bit1 kernel write, bit2 user read, bit3 user write). A matching entry whose bit is 0 raises `rspFault` with `rspPa` 0. `rspPa` is also 0 on a miss.
- R5: While `rspValid` is 1, exactly one of `rspHit`, `rspMiss`, `rspFault` is 1. While it is 0, all three are 0.
- R6: A miss drops `lkReady` in the same cycle as the miss response. It stays 0 until a cycle with `fillValid` high.
- R7: An entry written with `fillValid` is visible to a lookup accepted in the next cycle, and `lkReady` is 1 in the cycle after the fill. The retried address hits.
- R8: A fill whose tag already sits in the addressed set overwrites that way in place. Otherwise the fill takes an invalid way (way 0 first), and if there is none, the way named by a free-running one-bit toggle. Two tags coexist in a set, and a third evicts exactly one of them.
- R9: Addresses that differ only in bit 31 use separate storage and translate independently.
- R10: `invProc` clears only the per-process half and `invAll` clears both. An invalidate in the same cycle as a fill to the cleared half wins, leaving that entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkWrite | input | 1 | Lookup is a write |
| lkUser | input | 1 | Lookup is made in user mode |
| lkReady | output | 1 | Block accepts lookups (0 while waiting for a fill) |
| fillValid | input | 1 | Write an entry |
| fillVpn | input | 23 | Virtual page number (address bits 31:9) of the entry |
| fillPfn | input | 21 | Physical frame number of the entry |
| fillProt | input | 4 | Access-rights code of the entry |
| invAll | input | 1 | Invalidate both halves |
| invProc | input | 1 | Invalidate the per-process half |
| rspValid | output | 1 | Lookup result present |
| rspHit | output | 1 | Translation found and access allowed |
| rspMiss | output | 1 | No translation found |
| rspFault | output | 1 | Translation found but access denied |
| rspPa | output | 30 | Physical address, 0 unless `rspHit` |

## Verification
The checker watches the response protocol on every cycle. It checks that the one-hot outcome flags are present only when a response is, that each response follows an accepted lookup, that the page offset passes through and that the address is zero unless the lookup hits. It also checks that a miss parks the block until a fill and that the fill releases it. The bench scenarios cover what depends on stored contents. These are the frame numbers returned across every set of both halves, the rights decoding for all sixteen codes in all four access kinds, in-place refill and eviction of exactly one way, and the reach of each invalidate, including its race with a fill.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Associativity is fixed by the organisation of the block.
  localparam int WAYS = 2;
  localparam int HALF_PROC = 0;
  localparam int HALF_SYS = 1;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic doLookup;
    logic doFill;
    logic clrSys;
    logic clrProc;
  } xlStrobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lkValid,
  input  logic                  fillValid,
  input  logic                  invAll,
  input  logic                  invProc,
  input  logic                  lookupHit,
  output logic                  lkReady,
  output logic                  victimToggle,
  output xlate_pkg::xlStrobe_t  strb
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

  state_t state, stateNext;
  logic   toggleQ;

  always_comb begin
    strb.doLookup = lkValid && (state == ST_IDLE);
    strb.doFill   = fillValid;
    strb.clrSys   = invAll;
    strb.clrProc  = invAll || invProc;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.doLookup && !lookupHit) stateNext = ST_WAIT;
      ST_WAIT: if (fillValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      toggleQ <= 1'b0;
    end else begin
      state   <= stateNext;
      toggleQ <= ~toggleQ;
    end
  end

  assign lkReady      = (state == ST_IDLE);
  assign victimToggle = toggleQ;

endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 9,
  parameter int SETS      = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xlate_pkg::xlStrobe_t        strb,
  input  logic                        victimToggle,
  input  logic [VA_W-1:0]             lkVa,
  input  logic                        lkWrite,
  input  logic                        lkUser,
  input  logic [VA_W-PAGE_BITS-1:0]   fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]   fillPfn,
  input  logic [3:0]                  fillProt,
  output logic                        lookupHit,
  output logic                        rspValid,
  output logic                        rspHit,
  output logic                        rspMiss,
  output logic                        rspFault,
  output logic [PA_W-1:0]             rspPa
);
  import xlate_pkg::*;

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - 1 - IDX_W;

  // Storage: [half][set][way]
  logic             vldQ  [2][SETS][WAYS];
  logic [TAG_W-1:0] tagQ  [2][SETS][WAYS];
  logic [PFN_W-1:0] pfnQ  [2][SETS][WAYS];
  logic [3:0]       protQ [2][SETS][WAYS];

  // Lookup address fields
  logic             lkHalf;
  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;
  assign lkHalf = lkVa[VA_W-1];
  assign lkIdx  = lkVa[PAGE_BITS +: IDX_W];
  assign lkTag  = lkVa[PAGE_BITS+IDX_W +: TAG_W];

  // Fill address fields
  logic             fHalf;
  logic [IDX_W-1:0] fIdx;
  logic [TAG_W-1:0] fTag;
  assign fHalf = fillVpn[VPN_W-1];
  assign fIdx  = fillVpn[IDX_W-1:0];
  assign fTag  = fillVpn[IDX_W +: TAG_W];

  logic [WAYS-1:0] wayMatch, fillMatch, fillFree;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayMatch[w]  = vldQ[lkHalf][lkIdx][w] && (tagQ[lkHalf][lkIdx][w] == lkTag);
    assign fillMatch[w] = vldQ[fHalf][fIdx][w] && (tagQ[fHalf][fIdx][w] == fTag);
    assign fillFree[w]  = !vldQ[fHalf][fIdx][w];
  end

  // Lookup result selection
  logic             hitWay;
  logic [PFN_W-1:0] hitPfn;
  logic [3:0]       hitProt;
  logic             allow;

  assign lookupHit = |wayMatch;
  assign hitWay    = !wayMatch[0];
  assign hitPfn    = pfnQ[lkHalf][lkIdx][hitWay];
  assign hitProt   = protQ[lkHalf][lkIdx][hitWay];
  assign allow     = hitProt[{lkUser, lkWrite}];

  // Fill way: matching tag, then free way, then toggle
  logic fillWay;
  always_comb begin
    if (fillMatch[0])      fillWay = 1'b0;
    else if (fillMatch[1]) fillWay = 1'b1;
    else if (fillFree[0])  fillWay = 1'b0;
    else if (fillFree[1])  fillWay = 1'b1;
    else                   fillWay = victimToggle;
  end

  // Valid bits: fill first, invalidates override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            vldQ[h][s][w] <= 1'b0;
    end else begin
      if (strb.doFill) vldQ[fHalf][fIdx][fillWay] <= 1'b1;
      if (strb.clrSys)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            vldQ[HALF_SYS][s][w] <= 1'b0;
      if (strb.clrProc)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            vldQ[HALF_PROC][s][w] <= 1'b0;
    end
  end

  // Entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (strb.doFill) begin
      tagQ[fHalf][fIdx][fillWay]  <= fTag;
      pfnQ[fHalf][fIdx][fillWay]  <= fillPfn;
      protQ[fHalf][fIdx][fillWay] <= fillProt;
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
      rspPa    <= '0;
    end else begin
      rspValid <= strb.doLookup;
      rspHit   <= strb.doLookup && lookupHit && allow;
      rspFault <= strb.doLookup && lookupHit && !allow;
      rspMiss  <= strb.doLookup && !lookupHit;
      if (strb.doLookup && lookupHit && allow)
        rspPa <= {hitPfn, lkVa[PAGE_BITS-1:0]};
      else
        rspPa <= '0;
    end
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 9,
  parameter int SETS      = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lkValid,
  input  logic [VA_W-1:0]            lkVa,
  input  logic                       lkWrite,
  input  logic                       lkUser,
  output logic                       lkReady,
  input  logic                       fillValid,
  input  logic [VA_W-PAGE_BITS-1:0]  fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]  fillPfn,
  input  logic [3:0]                 fillProt,
  input  logic                       invAll,
  input  logic                       invProc,
  output logic                       rspValid,
  output logic                       rspHit,
  output logic                       rspMiss,
  output logic                       rspFault,
  output logic [PA_W-1:0]            rspPa
);

  xlate_pkg::xlStrobe_t strb;
  logic lookupHit;
  logic victimToggle;

  xlate_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lkValid      (lkValid),
    .fillValid    (fillValid),
    .invAll       (invAll),
    .invProc      (invProc),
    .lookupHit    (lookupHit),
    .lkReady      (lkReady),
    .victimToggle (victimToggle),
    .strb         (strb)
  );

  xlate_dpath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .SETS      (SETS)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .victimToggle (victimToggle),
    .lkVa         (lkVa),
    .lkWrite      (lkWrite),
    .lkUser       (lkUser),
    .fillVpn      (fillVpn),
    .fillPfn      (fillPfn),
    .fillProt     (fillProt),
    .lookupHit    (lookupHit),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspMiss      (rspMiss),
    .rspFault     (rspFault),
    .rspPa        (rspPa)
  );

endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lkValid,
  input logic                 lkReady,
  input logic [PAGE_BITS-1:0] lkOff,
  input logic                 fillValid,
  input logic                 rspValid,
  input logic                 rspHit,
  input logic                 rspMiss,
  input logic                 rspFault,
  input logic [PA_W-1:0]      rspPa
);

  // R5
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspFault}) == 1);

  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> {rspHit, rspMiss, rspFault} == 3'b000);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lkValid && lkReady));

  // R6
  miss_parks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> !lkReady);

  // R6
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lkReady && !fillValid) |=> !lkReady);

  // R7
  fill_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lkReady && fillValid) |=> lkReady);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspPa[PAGE_BITS-1:0] == $past(lkOff));

  // R4
  pa_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> rspPa == '0);

endmodule

bind xlate_cache xlate_cache_chk #(
  .PA_W      (PA_W),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lkValid   (lkValid),
  .lkReady   (lkReady),
  .lkOff     (lkVa[PAGE_BITS-1:0]),
  .fillValid (fillValid),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspMiss   (rspMiss),
  .rspFault  (rspFault),
  .rspPa     (rspPa)
);

// File: tb/xlate_cache_tb.sv
`timescale 1ns/1ps
module xlate_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkWrite = 1'b0, lkUser = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkReady;
  logic        fillValid = 1'b0;
  logic [22:0] fillVpn = '0;
  logic [20:0] fillPfn = '0;
  logic [3:0]  fillProt = '0;
  logic        invAll = 1'b0, invProc = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspFault;
  logic [29:0] rspPa;

  int total = 0;
  int bad = 0;
  bit gotV, gotH, gotM, gotF;
  logic [29:0] gotPa;

  always #4 clk = ~clk;

  xlate_cache u_dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .lkWrite(lkWrite),
    .lkUser(lkUser), .lkReady(lkReady), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPfn(fillPfn), .fillProt(fillProt), .invAll(invAll), .invProc(invProc),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspPa(rspPa)
  );

  function automatic logic [31:0] mkVa(int h, int s, int t, int o);
    logic [31:0] v;
    v = ((h & 1) << 31) | ((t & 'h1FFFF) << 14) | ((s & 31) << 9) | (o & 511);
    return v;
  endfunction

  function automatic logic [20:0] pfnOf(int h, int s, int t);
    int p;
    p = (h * 'h15555) ^ (s * 977) ^ (t * 31) ^ 'h5A;
    return p[20:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input bit wr, input bit user);
    @(negedge clk);
    lkVa = a; lkWrite = wr; lkUser = user; lkValid = 1'b1;
    @(negedge clk);
    lkValid = 1'b0;
    gotV = rspValid; gotH = rspHit; gotM = rspMiss; gotF = rspFault; gotPa = rspPa;
  endtask

  task automatic fill(input logic [31:0] a, input logic [20:0] p, input logic [3:0] pr);
    @(negedge clk);
    fillVpn = a[31:9]; fillPfn = p; fillProt = pr; fillValid = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic expectHit(input logic [31:0] a, input logic [20:0] p, input string req);
    look(a, 1'b0, 1'b0);
    chk(gotV && gotH && !gotM && !gotF, req, {gotV, gotH, gotM, gotF}, 4'b1100);
    chk(gotPa == {p, a[8:0]}, req, gotPa, {p, a[8:0]});
  endtask

  // Miss, then release the wait by filling relA
  task automatic expectMiss(input logic [31:0] a, input logic [31:0] relA,
                            input logic [20:0] relP, input string req);
    look(a, 1'b0, 1'b0);
    chk(gotV && gotM && !gotH && !gotF && gotPa == 0, req, {gotV, gotH, gotM, gotF}, 4'b1010);
    fill(relA, relP, 4'hF);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] a, b;
    bit h0, h1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lkReady == 1'b1, "R1", lkReady, 1);
    chk(rspValid == 1'b0, "R1", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(lkReady == 1'b1 && rspValid == 1'b0, "R1", {lkReady, rspValid}, 2'b10);

    // R1/R6: first lookup misses and parks the block
    a = mkVa(0, 3, 9, 'h1AB);
    look(a, 1'b0, 1'b0);
    chk(gotV && gotM, "R1", {gotV, gotM}, 2'b11);
    chk(lkReady == 1'b0, "R6", lkReady, 0);
    // R2/R6: lookups while parked are dropped
    look(mkVa(0, 4, 4, 0), 1'b0, 1'b0);
    chk(!gotV && !gotH && !gotM && !gotF, "R2", {gotV, gotH, gotM, gotF}, 0);
    chk(lkReady == 1'b0, "R6", lkReady, 0);
    // R7: fill releases, retry hits
    fill(a, pfnOf(0, 3, 9), 4'hF);
    chk(lkReady == 1'b1, "R7", lkReady, 1);
    expectHit(a, pfnOf(0, 3, 9), "R7");

    // R10: invAll drops it
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
    expectMiss(a, a, pfnOf(0, 3, 9), "R10");
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;

    // R3/R8/R9: two tags in every set of both halves
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 32; s++) begin
        fill(mkVa(h, s, s + 5, 0), pfnOf(h, s, s + 5), 4'hF);
        fill(mkVa(h, s, s + 700, 0), pfnOf(h, s, s + 700), 4'hF);
      end
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 32; s++) begin
        expectHit(mkVa(h, s, s + 5, s * 13), pfnOf(h, s, s + 5), h ? "R9" : "R3");
        expectHit(mkVa(h, s, s + 700, s * 7 + 1), pfnOf(h, s, s + 700), "R8");
      end

    // R4: all rights codes and access kinds, refilled in place (R8)
    for (int pr = 0; pr < 16; pr++) begin
      fill(mkVa(0, 0, 5, 0), pfnOf(0, 0, pr), 4'(pr));
      for (int u = 0; u < 2; u++)
        for (int w = 0; w < 2; w++) begin
          bit ok;
          ok = pr[u * 2 + w];
          look(mkVa(0, 0, 5, 'h55), 1'(w), 1'(u));
          chk(gotV && gotH == ok && gotF == !ok && !gotM, "R4", {gotH, gotF}, {ok, !ok});
          chk(gotPa == (ok ? {pfnOf(0, 0, pr), 9'h55} : 30'h0), "R4", gotPa,
              ok ? {pfnOf(0, 0, pr), 9'h55} : 30'h0);
        end
    end
    expectHit(mkVa(0, 0, 700, 3), pfnOf(0, 0, 700), "R8");

    // R8: third tag evicts exactly one of two
    fill(mkVa(1, 5, 3000, 0), pfnOf(1, 5, 3000), 4'hF);
    expectHit(mkVa(1, 5, 3000, 2), pfnOf(1, 5, 3000), "R8");
    look(mkVa(1, 5, 10, 0), 1'b0, 1'b0);
    h0 = gotH;
    if (!gotH) fill(mkVa(1, 6, 11, 0), pfnOf(1, 6, 11), 4'hF);
    look(mkVa(1, 5, 705, 0), 1'b0, 1'b0);
    h1 = gotH;
    if (!gotH) fill(mkVa(1, 6, 11, 0), pfnOf(1, 6, 11), 4'hF);
    chk(h0 ^ h1, "R8", {h0, h1}, 2'b01);

    // R10: invProc clears only the per-process half
    @(negedge clk); invProc = 1'b1;
    @(negedge clk); invProc = 1'b0;
    expectHit(mkVa(1, 10, 15, 8), pfnOf(1, 10, 15), "R10");
    expectMiss(mkVa(0, 10, 15, 8), mkVa(1, 10, 15, 0), pfnOf(1, 10, 15), "R10");
    chk(lkReady == 1'b1, "R7", lkReady, 1);

    // R10: invalidate beats same-cycle fill
    b = mkVa(0, 12, 77, 0);
    @(negedge clk);
    fillVpn = b[31:9]; fillPfn = pfnOf(0, 12, 77); fillProt = 4'hF;
    fillValid = 1'b1; invProc = 1'b1;
    @(negedge clk);
    fillValid = 1'b0; invProc = 1'b0;
    expectMiss(b, mkVa(1, 10, 15, 0), pfnOf(1, 10, 15), "R10");

    // R10: invAll clears the system half too
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
    expectMiss(mkVa(1, 20, 720, 0), mkVa(1, 20, 720, 0), pfnOf(1, 20, 720), "R10");
    expectHit(mkVa(1, 20, 720, 9), pfnOf(1, 20, 720), "R7");

    finishRun();
  end

endmodule